// File: doc/BRIEF.md
# Threshold Offset Loader

This block stores the two programmable distances that a FIFO's flag logic compares against: the almost-empty distance `n` and the almost-full distance `m`. Each distance is split into a low byte slot and a high slot. A host reaches the four slots through the FIFO's own data pins. It holds one load strobe low, and every accepted write-clock edge stores the input word into the slot the cursor points at. Every accepted read-clock edge copies the selected slot onto the readback output. After each access the cursor advances, and after the fourth slot it returns to the first.

The cursor is not cleared when the strobe goes high. A later session therefore starts at the slot after the last one touched, and a host can update any subset of the slots over several short sessions. Whether the strobe pin acts as a load strobe at all is fixed while reset is held. If the pin is low during reset, programming is enabled. If it is high, the pin is left to the FIFO as a second write enable and the block ignores it. The slot widths follow the FIFO depth, and the assembled `n` and `m` are `log2(DEPTH)` bits wide.

Top module: `thresh_offset_loader`

## Requirements
- R1: After reset, `empty_off` and `full_off` both equal 7, `q` is 0 and `q_vld` is 0.
- R2: In programming mode, each write-clock edge with `ld_n`=0 and `wen1_n`=0 stores `din` into the next slot. The slot order is: cursor 0 = empty low byte, 1 = empty high part, 2 = full low byte, 3 = full high part. `empty_off` is {slot1, slot0[7:0]} and `full_off` is {slot3, slot2[7:0]}, and both take the new value on that edge.
- R3: The write after the one to cursor 3 goes to cursor 0 again.
- R4: Raising `ld_n` ends a session without moving the cursor. The first access of the next session uses the slot after the last one accessed.
- R5: In programming mode, each read-clock edge with `ld_n`, `ren1_n` and `ren2_n` all 0 places the selected slot, zero-extended, on `q`. The same edge raises `q_vld` for one cycle and advances the same cursor that writes use.
- R6: The low slots keep min(OFF_W,8) bits and the high slots keep max(OFF_W-8,0) bits of `din`, where OFF_W = log2(DEPTH). Bits that are not kept read back as 0. A write to a high slot that has no bits leaves the outputs unchanged, but it still advances the cursor.
- R7: An edge with `wen1_n`=1, or with `ld_n`=1, changes no slot and does not move the cursor.
- R8: A read-clock edge where either read enable is 1, or where `ld_n` is 1, leaves `q` unchanged, keeps `q_vld` at 0 and does not move the cursor.
- R9: If `ld_n` is 1 while reset is held, no later strobe activity changes the offsets or produces a readback.
- R10: A new reset restores both offsets to 7 and returns the cursor to cursor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe; its level during reset selects programming mode |
| wen1_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| din | input | DATA_W | Write data |
| q | output | DATA_W | Last slot read back |
| q_vld | output | 1 | One read-clock pulse after a readback |
| empty_off | output | OFF_W | Almost-empty distance n |
| full_off | output | OFF_W | Almost-full distance m |

## Verification
The bench drives two instances from the same stimulus. One is built with DEPTH=64: its offsets are 6 bits wide and it has no high-slot bits, so it shows the truncation and the case where a write to a high slot only moves the cursor. The other is built with DEPTH=1024: its offsets are 10 bits wide and it has 2-bit high slots, so it shows how the high part reaches `n` and `m`. The write clock and the read clock run at unrelated periods, so the shared cursor has to cross between the two domains at every change from writes to readbacks.

// File: rtl/tol_pkg.sv
package tol_pkg;
  localparam int unsigned N_SLOTS = 4;
  localparam int unsigned LANE_W  = 8;
  localparam logic [LANE_W-1:0] DEF_LO = 8'h07;

  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  function automatic logic [1:0] to_gray(input logic [1:0] b);
    return {b[1], b[1] ^ b[0]};
  endfunction

  function automatic logic [1:0] from_gray(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/tol_rst_sync.sv
module tol_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/tol_gray_sync.sv
module tol_gray_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] gray_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= gray_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign gray_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tol_bank.sv
module tol_bank
  import tol_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned OFF_W = $clog2(DEPTH),
  localparam int unsigned LO_W  = (OFF_W < LANE_W) ? OFF_W : LANE_W,
  localparam int unsigned HI_W  = (OFF_W > LANE_W) ? OFF_W - LANE_W : 0,
  localparam int unsigned HI_D  = (HI_W > 0) ? HI_W : 1
) (
  input  logic                             wclk,
  input  logic                             wrst_n,
  input  logic                             ld_n,
  input  logic                             wen1_n,
  input  logic [DATA_W-1:0]                din,
  input  logic [1:0]                       rstep_gray,
  output logic [1:0]                       wstep_gray,
  output logic [N_SLOTS-1:0][DATA_W-1:0]   slot_view,
  output logic [OFF_W-1:0]                 empty_off,
  output logic [OFF_W-1:0]                 full_off
);
  localparam logic [OFF_W-1:0] DEF_OFF = OFF_W'(7);

  logic            prog_q;
  logic            wr_hit;
  logic [1:0]      rstep_sync;
  logic [1:0]      wcnt_q, wcnt_d;
  logic [1:0]      wgray_q, wgray_d;
  slot_e           sel;
  logic [LO_W-1:0] e_lo_q, e_lo_d, f_lo_q, f_lo_d;
  logic [HI_D-1:0] e_hi, f_hi;

  // mode capture: tracks the strobe only while reset is held
  always_ff @(posedge wclk) begin
    if (!wrst_n) prog_q <= ~ld_n;
  end

  assign wr_hit = prog_q & ~ld_n & ~wen1_n;

  tol_gray_sync #(.W(2), .STAGES(2)) u_rstep_sync (
    .clk    (wclk),
    .rst_n  (wrst_n),
    .gray_i (rstep_gray),
    .gray_o (rstep_sync)
  );

  // cursor = own steps + steps taken by the read side
  assign sel = slot_e'(wcnt_q + from_gray(rstep_sync));

  always_comb begin
    wcnt_d  = wcnt_q;
    e_lo_d  = e_lo_q;
    f_lo_d  = f_lo_q;
    if (wr_hit) begin
      wcnt_d = wcnt_q + 2'd1;
      if (sel == SLOT_E_LO) e_lo_d = din[LO_W-1:0];
      if (sel == SLOT_F_LO) f_lo_d = din[LO_W-1:0];
    end
    wgray_d = to_gray(wcnt_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wcnt_q  <= '0;
      wgray_q <= '0;
      e_lo_q  <= LO_W'(DEF_LO);
      f_lo_q  <= LO_W'(DEF_LO);
    end else begin
      wcnt_q  <= wcnt_d;
      wgray_q <= wgray_d;
      e_lo_q  <= e_lo_d;
      f_lo_q  <= f_lo_d;
    end
  end

  if (HI_W > 0) begin : g_hi
    logic [HI_D-1:0] e_hi_q, e_hi_d, f_hi_q, f_hi_d;

    always_comb begin
      e_hi_d = e_hi_q;
      f_hi_d = f_hi_q;
      if (wr_hit && sel == SLOT_E_HI) e_hi_d = din[HI_D-1:0];
      if (wr_hit && sel == SLOT_F_HI) f_hi_d = din[HI_D-1:0];
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
        e_hi_q <= '0;
        f_hi_q <= '0;
      end else begin
        e_hi_q <= e_hi_d;
        f_hi_q <= f_hi_d;
      end
    end

    assign e_hi      = e_hi_q;
    assign f_hi      = f_hi_q;
    assign empty_off = {e_hi_q, e_lo_q};
    assign full_off  = {f_hi_q, f_lo_q};
  end else begin : g_no_hi
    assign e_hi      = '0;
    assign f_hi      = '0;
    assign empty_off = OFF_W'(e_lo_q);
    assign full_off  = OFF_W'(f_lo_q);
  end

  assign slot_view[SLOT_E_LO] = DATA_W'(e_lo_q);
  assign slot_view[SLOT_E_HI] = (HI_W > 0) ? DATA_W'(e_hi) : '0;
  assign slot_view[SLOT_F_LO] = DATA_W'(f_lo_q);
  assign slot_view[SLOT_F_HI] = (HI_W > 0) ? DATA_W'(f_hi) : '0;
  assign wstep_gray = wgray_q;

  logic unused_din_bits;
  assign unused_din_bits = ^din;

  assert_cursor_moves_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_hit |=> (wcnt_q != $past(wcnt_q)));

  assert_idle_holds_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_hit |=> ($stable(slot_view) && $stable(wcnt_q)));

  assert_mode_frozen_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    $stable(prog_q));

  assert_defaults_kept_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    !prog_q |-> (empty_off == DEF_OFF && full_off == DEF_OFF));

  assert_upper_clear_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    ((slot_view[SLOT_E_LO] >> LO_W) == '0) && ((slot_view[SLOT_F_LO] >> LO_W) == '0));
endmodule

// File: rtl/tol_readback.sv
module tol_readback
  import tol_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic                           rclk,
  input  logic                           rrst_n,
  input  logic                           ld_n,
  input  logic                           ren1_n,
  input  logic                           ren2_n,
  input  logic [N_SLOTS-1:0][DATA_W-1:0] slot_view,
  input  logic [1:0]                     wstep_gray,
  output logic [1:0]                     rstep_gray,
  output logic [DATA_W-1:0]              q,
  output logic                           q_vld
);
  logic              prog_r;
  logic              rd_hit;
  logic [1:0]        wstep_sync;
  logic [1:0]        rcnt_q, rcnt_d;
  logic [1:0]        rgray_q, rgray_d;
  logic [DATA_W-1:0] q_q, q_d;
  logic              vld_q, vld_d;
  slot_e             sel;

  always_ff @(posedge rclk) begin
    if (!rrst_n) prog_r <= ~ld_n;
  end

  assign rd_hit = prog_r & ~ld_n & ~ren1_n & ~ren2_n;

  tol_gray_sync #(.W(2), .STAGES(2)) u_wstep_sync (
    .clk    (rclk),
    .rst_n  (rrst_n),
    .gray_i (wstep_gray),
    .gray_o (wstep_sync)
  );

  assign sel = slot_e'(rcnt_q + from_gray(wstep_sync));

  always_comb begin
    rcnt_d = rcnt_q;
    q_d    = q_q;
    vld_d  = 1'b0;
    if (rd_hit) begin
      rcnt_d = rcnt_q + 2'd1;
      q_d    = slot_view[sel];
      vld_d  = 1'b1;
    end
    rgray_d = to_gray(rcnt_d);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rcnt_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
      vld_q   <= 1'b0;
    end else begin
      rcnt_q  <= rcnt_d;
      rgray_q <= rgray_d;
      q_q     <= q_d;
      vld_q   <= vld_d;
    end
  end

  assign rstep_gray = rgray_q;
  assign q          = q_q;
  assign q_vld      = vld_q;

  assert_q_holds_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_hit |=> $stable(q_q));

  assert_vld_from_pins_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    vld_q |-> $past(~ld_n & ~ren1_n & ~ren2_n));

  assert_no_readback_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    !prog_r |-> !vld_q);
endmodule

// File: rtl/thresh_offset_loader.sv
module thresh_offset_loader
  import tol_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              wen1_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              q_vld,
  output logic [OFF_W-1:0]  empty_off,
  output logic [OFF_W-1:0]  full_off
);
  logic                           wrst_n, rrst_n;
  logic [1:0]                     wstep_gray, rstep_gray;
  logic [N_SLOTS-1:0][DATA_W-1:0] slot_view;

  tol_rst_sync u_wrst (.clk(wclk), .rst_n_i(rst_n), .rst_n_o(wrst_n));
  tol_rst_sync u_rrst (.clk(rclk), .rst_n_i(rst_n), .rst_n_o(rrst_n));

  tol_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
    .wclk       (wclk),
    .wrst_n     (wrst_n),
    .ld_n       (ld_n),
    .wen1_n     (wen1_n),
    .din        (din),
    .rstep_gray (rstep_gray),
    .wstep_gray (wstep_gray),
    .slot_view  (slot_view),
    .empty_off  (empty_off),
    .full_off   (full_off)
  );

  tol_readback #(.DATA_W(DATA_W)) u_readback (
    .rclk       (rclk),
    .rrst_n     (rrst_n),
    .ld_n       (ld_n),
    .ren1_n     (ren1_n),
    .ren2_n     (ren2_n),
    .slot_view  (slot_view),
    .wstep_gray (wstep_gray),
    .rstep_gray (rstep_gray),
    .q          (q),
    .q_vld      (q_vld)
  );
endmodule

// File: tb/test_thresh_offset_loader.sv
`timescale 1ns/1ps
module test_thresh_offset_loader;
  localparam int DW   = 9;
  localparam int OW_A = 6;
  localparam int OW_B = 10;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  logic rst_n, ld_n, wen1_n, ren1_n, ren2_n;
  logic [DW-1:0]   din;
  logic [DW-1:0]   q_a, q_b;
  logic            qv_a, qv_b;
  logic [OW_A-1:0] n_a, m_a;
  logic [OW_B-1:0] n_b, m_b;

  thresh_offset_loader #(.DEPTH(64), .DATA_W(DW)) i_thresh_offset_loader (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .q(q_a), .q_vld(qv_a),
    .empty_off(n_a), .full_off(m_a));

  thresh_offset_loader #(.DEPTH(1024), .DATA_W(DW)) i_thresh_offset_loader_1k (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .q(q_b), .q_vld(qv_b),
    .empty_off(n_b), .full_off(m_b));

  int errs = 0;
  int checks = 0;
  int cur = 0;
  bit prog_m = 1'b1;
  logic [DW-1:0] ma [4];
  logic [DW-1:0] mb [4];

  function automatic logic [DW-1:0] fit(int ow, int slot, logic [DW-1:0] v);
    int lw = (ow < 8) ? ow : 8;
    int hw = (ow > 8) ? ow - 8 : 0;
    int w  = (slot % 2 == 1) ? hw : lw;
    return v & DW'((1 << w) - 1);
  endfunction

  function automatic int off_of(int ow, logic [DW-1:0] lo, logic [DW-1:0] hi);
    return ((int'(hi) << 8) | int'(lo)) & ((1 << ow) - 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_offsets(string req);
    chk(req, "n 64", int'(n_a), off_of(OW_A, ma[0], ma[1]));
    chk(req, "m 64", int'(m_a), off_of(OW_A, ma[2], ma[3]));
    chk(req, "n 1k", int'(n_b), off_of(OW_B, mb[0], mb[1]));
    chk(req, "m 1k", int'(m_b), off_of(OW_B, mb[2], mb[3]));
  endtask

  task automatic do_reset(logic ld_level);
    ld_n = ld_level; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; din = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge rclk);
    rst_n = 1'b1;
    repeat (5) @(negedge rclk);
    for (int s = 0; s < 4; s++) begin
      ma[s] = fit(OW_A, s, (s % 2 == 0) ? 9'h007 : 9'h000);
      mb[s] = fit(OW_B, s, (s % 2 == 0) ? 9'h007 : 9'h000);
    end
    cur = 0;
    prog_m = ~ld_level;
  endtask

  task automatic wr(logic [DW-1:0] v);
    @(negedge wclk);
    ld_n = 1'b0; wen1_n = 1'b0; din = v;
    @(negedge wclk);
    wen1_n = 1'b1;
    if (prog_m) begin
      ma[cur] = fit(OW_A, cur, v);
      mb[cur] = fit(OW_B, cur, v);
      cur = (cur + 1) % 4;
    end
  endtask

  task automatic end_session();
    @(negedge wclk);
    ld_n = 1'b1;
    repeat (4) @(negedge rclk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic rd(string req);
    @(negedge rclk);
    ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    chk(req, "q 64", int'(q_a), int'(ma[cur]));
    chk(req, "q 1k", int'(q_b), int'(mb[cur]));
    chk(req, "q_vld", int'({qv_a, qv_b}), 3);
    cur = (cur + 1) % 4;
    @(negedge rclk);
    chk(req, "q_vld drop", int'({qv_a, qv_b}), 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk_offsets("R1");
    chk("R1", "n 64 is 7", int'(n_a), 7);
    chk("R1", "m 1k is 7", int'(m_b), 7);
    chk("R1", "q", int'(q_a) + int'(q_b), 0);
    chk("R1", "q_vld", int'({qv_a, qv_b}), 0);
  endtask

  task automatic t_sequence();
    wr(9'h15A); chk_offsets("R2");
    chk("R2", "n 1k low byte", int'(n_b), 9'h05A);
    wr(9'h0C3); chk_offsets("R2");
    chk("R2", "n 1k high part", int'(n_b), 10'h35A);
    wr(9'h021); chk_offsets("R2");
    wr(9'h1F2); chk_offsets("R2");
    chk("R2", "m 1k", int'(m_b), 10'h221);
  endtask

  task automatic t_wrap();
    wr(9'h00B);
    chk_offsets("R3");
    chk("R3", "slot0 again 64", int'(n_a), 6'h0B);
    chk("R3", "m kept 1k", int'(m_b), 10'h221);
  endtask

  task automatic t_sessions();
    end_session();
    wr(9'h001);
    chk_offsets("R4");
    chk("R4", "next slot is empty high", int'(n_b), 10'h10B);
    chk("R6", "no high bits 64", int'(n_a), 6'h0B);
    end_session();
    wr(9'h033);
    chk_offsets("R4");
    chk("R4", "then full low", int'(m_a), 6'h33);
    end_session();
  endtask

  task automatic t_write_gate();
    @(negedge wclk); ld_n = 1'b0; wen1_n = 1'b1; din = 9'h0AA;
    repeat (2) @(negedge wclk);
    chk_offsets("R7");
    @(negedge wclk); ld_n = 1'b1; wen1_n = 1'b0; din = 9'h055;
    repeat (2) @(negedge wclk);
    wen1_n = 1'b1;
    chk_offsets("R7");
    wr(9'h002);
    chk_offsets("R7");
    chk("R7", "cursor kept: full high", int'(m_b), 10'h233);
    end_session();
  endtask

  task automatic t_readback();
    settle();
    for (int k = 0; k < 5; k++) rd("R5");
    end_session();
    settle();
    wr(9'h010);
    chk_offsets("R5");
    end_session();
    settle();
  endtask

  task automatic t_read_gate();
    logic [DW-1:0] qa0, qb0;
    qa0 = q_a; qb0 = q_b;
    @(negedge rclk); ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b0;
    @(negedge rclk);
    chk("R8", "q 64 hold", int'(q_a), int'(qa0));
    chk("R8", "q_vld one enable", int'({qv_a, qv_b}), 0);
    ren2_n = 1'b1;
    @(negedge rclk); ld_n = 1'b1; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk);
    chk("R8", "q 1k hold", int'(q_b), int'(qb0));
    chk("R8", "q_vld strobe high", int'({qv_a, qv_b}), 0);
    ren1_n = 1'b1; ren2_n = 1'b1;
    rd("R8");
    end_session();
    settle();
  endtask

  task automatic t_width();
    for (int k = 0; k < 4; k++) wr(9'h1FF);
    chk_offsets("R6");
    chk("R6", "n 64 trunc", int'(n_a), 6'h3F);
    chk("R6", "n 1k trunc", int'(n_b), 10'h3FF);
    end_session();
    settle();
    rd("R6");
    rd("R6");
    end_session();
    settle();
  endtask

  task automatic t_reset_restore();
    wr(9'h0F0);
    end_session();
    do_reset(1'b0);
    chk_offsets("R10");
    chk("R10", "n 1k default", int'(n_b), 7);
    wr(9'h011);
    chk("R10", "first slot after reset", int'(n_b), 10'h011);
    chk_offsets("R10");
    end_session();
  endtask

  task automatic t_two_enable();
    do_reset(1'b1);
    wr(9'h0EE);
    wr(9'h0DD);
    chk_offsets("R9");
    chk("R9", "n 64 default", int'(n_a), 7);
    settle();
    @(negedge rclk); ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R9", "no readback", int'({qv_a, qv_b}), 0);
    chk("R9", "q stays 0", int'(q_a) + int'(q_b), 0);
    end_session();
  endtask

  initial begin
    #600000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_wrap();
    t_sessions();
    t_write_gate();
    t_readback();
    t_read_gate();
    t_width();
    t_reset_restore();
    t_two_enable();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule